// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This block computes one multiply-accumulate step for a signed fixed-point datapath in a single clock. Two 16-bit operands are widened to 17 bits, either by sign extension or by zero extension. They are multiplied as signed values. For Q15 data the product can be doubled. The one product that leaves the Q31 range, a most-negative number squared, can be clamped. The product is then added to or subtracted from a 40-bit accumulator value supplied at the input. The 40-bit accumulator holds 8 guard bits above a 32-bit core.

After the add or subtract, the sum can be rounded at bit 16 in one of two ways. Overflow is then judged against either the 32-bit or the full 40-bit signed range. When saturation is enabled, the result is clamped to the matching bound. The result, a carry flag and a sticky overflow flag are registered. A result appears one clock after an input is accepted.

The surrounding datapath owns the accumulator storage. It feeds the old value in and writes the registered result back.

Top module: `fmac_sat_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `acc_out`, `carry` and `out_valid` show that operation's results after that edge. When `in_valid` is low, `out_valid` goes low, and `acc_out` and `carry` keep their values whatever the other inputs do.
- R2: With `sext_en`=1 each 16-bit operand is sign-extended to 17 bits before the signed multiply. With `sext_en`=0 it is zero-extended.
- R3: With `frac_en`=1 the 34-bit product is shifted left by one bit before accumulation. With `frac_en`=0 it is used unshifted.
- R4: With `prod_sat_en`=1, a product (after any shift) equal to exactly 2^31 is replaced by 2^31-1 before the add or subtract.
- R5: With `sub_sel`=0 the product is added to `acc_in`, taken as a signed 40-bit value. With `sub_sel`=1 the product is subtracted from it. The sum is formed exactly, without wrap.
- R6: `rnd_sel`=01 adds 8000h to the sum and clears bits 15..0. `rnd_sel`=00 and 11 leave the sum unrounded.
- R7: `rnd_sel`=10 rounds the sum to the nearest multiple of 10000h, and an exact half rounds toward the value whose bit 16 is 0. Bits 15..0 are then cleared.
- R8: Overflow is the rounded sum lying outside the signed 32-bit range when `wide_en`=0, or outside the signed 40-bit range when `wide_en`=1. With `sat_en`=0 the low 40 bits of the rounded sum are output, wrapping.
- R9: With `sat_en`=1 and `wide_en`=0, an overflow gives 00_7FFF_FFFFh for a positive sum and FF_8000_0000h for a negative one.
- R10: With `sat_en`=1 and `wide_en`=1, an overflow gives 7F_FFFF_FFFFh for a positive sum and 80_0000_0000h for a negative one.
- R11: `carry` is the carry out of bit 31 (`wide_en`=0) or of bit 39 (`wide_en`=1) when `acc_in` is added to Q, plus the value of `sub_sel`. Q is the 40-bit product when `sub_sel`=0 and its bitwise inverse when `sub_sel`=1. The carry is taken before rounding.
- R12: `ovf_sticky` is set after any accepted operation that overflows. It stays set until a cycle with `ovf_clr` high and no overflowing operation, which clears it. An overflow in the same cycle as `ovf_clr` leaves it set.
- R13: After reset, `acc_out`=0, `carry`=0, `ovf_sticky`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| opnd_x | input | 16 | First multiplier operand |
| opnd_y | input | 16 | Second multiplier operand |
| acc_in | input | 40 | Accumulator value to add to or subtract from |
| sub_sel | input | 1 | 1 = subtract the product, 0 = add it |
| frac_en | input | 1 | Double the product (Q15 x Q15 to Q31) |
| prod_sat_en | input | 1 | Clamp a product of exactly 2^31 to 2^31-1 |
| wide_en | input | 1 | 1 = 40-bit overflow and carry limits, 0 = 32-bit |
| sat_en | input | 1 | Saturate the result on overflow |
| sext_en | input | 1 | Sign-extend the operands (else zero-extend) |
| rnd_sel | input | 2 | 00/11 none, 01 half-up, 10 half-to-even at bit 16 |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| acc_out | output | 40 | Registered result |
| out_valid | output | 1 | Result registered in the previous cycle |
| carry | output | 1 | Registered carry flag |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach are those where several stages bite at once. One is the clamped most-negative square landing on an accumulator already at a saturation bound. Another is a rounding tie, where the sum's low half must be exactly 8000h with a chosen bit 16. The stimulus reaches them with a small operand set built from extreme values (0, 1, 7FFFh, 8000h, FFFFh) plus one ordinary value. This set is crossed with accumulator values placed on both saturation bounds and on exact rounding ties. Every combination of the eight mode bits is applied to each pair, and the bench works out each expected result with 64-bit integer arithmetic.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

   typedef enum logic [1:0] {
      RND_OFF      = 2'b00,
      RND_HALF_UP  = 2'b01,
      RND_HALF_EVN = 2'b10,
      RND_OFF_ALT  = 2'b11
   } rnd_kind_e;

   typedef struct packed {
      logic      sub;
      logic      frac;
      logic      psat;
      logic      wide;
      logic      sat;
      logic      sext;
      rnd_kind_e rnd;
   } mac_mode_t;

endpackage

// File: rtl/fmac_product.sv
module fmac_product
   import fmac_pkg::*;
#(
   parameter int OP_W = 16,
   localparam int PW  = 2 * OP_W + 3
) (
   input  logic [OP_W-1:0]        opnd_x,
   input  logic [OP_W-1:0]        opnd_y,
   input  mac_mode_t              mode,
   output logic signed [PW-1:0]   prod
);
   localparam int RAW_W = 2 * OP_W + 2;
   localparam logic signed [PW-1:0] Q_EDGE = PW'(1) <<< (2 * OP_W - 1);

   logic signed [OP_W:0]    x_ext, y_ext;
   logic signed [RAW_W-1:0] raw;
   logic signed [PW-1:0]    scaled;

   always_comb begin
      x_ext  = {mode.sext & opnd_x[OP_W-1], opnd_x};
      y_ext  = {mode.sext & opnd_y[OP_W-1], opnd_y};
      raw    = x_ext * y_ext;
      scaled = mode.frac ? {raw, 1'b0} : {raw[RAW_W-1], raw};
      if (mode.psat && (scaled == Q_EDGE)) begin
         prod = Q_EDGE - PW'(1);
      end else begin
         prod = scaled;
      end
   end
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
   import fmac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40,
   localparam int PW   = 2 * OP_W + 3,
   localparam int SW   = ACC_W + 2,
   localparam int NB   = 2 * OP_W
) (
   input  logic [ACC_W-1:0]      acc_in,
   input  logic signed [PW-1:0]  prod,
   input  mac_mode_t             mode,
   output logic signed [SW-1:0]  sum,
   output logic                  carry
);
   logic signed [SW-1:0] acc_x, prod_x;
   logic [ACC_W-1:0]     prod_a, addend;
   logic [ACC_W:0]       full_add;
   logic [NB:0]          low_add;

   always_comb begin
      acc_x  = {{2{acc_in[ACC_W-1]}}, acc_in};
      prod_x = {{(SW-PW){prod[PW-1]}}, prod};
      sum    = mode.sub ? (acc_x - prod_x) : (acc_x + prod_x);

      prod_a   = prod_x[ACC_W-1:0];
      addend   = mode.sub ? ~prod_a : prod_a;
      full_add = {1'b0, acc_in} + {1'b0, addend} + (ACC_W+1)'(mode.sub);
      low_add  = {1'b0, acc_in[NB-1:0]} + {1'b0, addend[NB-1:0]} + (NB+1)'(mode.sub);
      carry    = mode.wide ? full_add[ACC_W] : low_add[NB];
   end
endmodule

// File: rtl/fmac_round.sv
module fmac_round
   import fmac_pkg::*;
#(
   parameter int OP_W      = 16,
   parameter int SW        = 42,
   parameter bit EVEN_RND  = 1'b1
) (
   input  logic signed [SW-1:0] sum,
   input  rnd_kind_e            rnd,
   output logic signed [SW-1:0] rounded
);
   logic [OP_W-1:0]      frac_part;
   logic signed [SW-1:0] trunc;
   logic                 half_up, half_evn, bump;

   always_comb begin
      frac_part = sum[OP_W-1:0];
      trunc     = {sum[SW-1:OP_W], {OP_W{1'b0}}};
      half_up   = frac_part[OP_W-1];
   end

   generate
      if (EVEN_RND) begin : g_even
         always_comb half_evn = frac_part[OP_W-1] & ((|frac_part[OP_W-2:0]) | sum[OP_W]);
      end else begin : g_no_even
         always_comb half_evn = half_up;
      end
   endgenerate

   always_comb begin
      unique case (rnd)
         RND_HALF_UP:  bump = half_up;
         RND_HALF_EVN: bump = half_evn;
         default:      bump = 1'b0;
      endcase
      if (rnd == RND_HALF_UP || rnd == RND_HALF_EVN) begin
         rounded = trunc + (SW'(bump) <<< OP_W);
      end else begin
         rounded = sum;
      end
   end
endmodule

// File: rtl/fmac_saturate.sv
module fmac_saturate
   import fmac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40,
   localparam int SW   = ACC_W + 2,
   localparam int NB   = 2 * OP_W
) (
   input  logic signed [SW-1:0] rounded,
   input  mac_mode_t            mode,
   output logic [ACC_W-1:0]     res,
   output logic                 ovf
);
   localparam logic [ACC_W-1:0] HI_WIDE = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] LO_WIDE = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] HI_NARR = {{(ACC_W-NB+1){1'b0}}, {(NB-1){1'b1}}};
   localparam logic [ACC_W-1:0] LO_NARR = {{(ACC_W-NB+1){1'b1}}, {(NB-1){1'b0}}};

   logic [SW-ACC_W:0] top_w;
   logic [SW-NB:0]    top_n;
   logic              ovf_w, ovf_n, neg;

   always_comb begin
      top_w = rounded[SW-1:ACC_W-1];
      top_n = rounded[SW-1:NB-1];
      ovf_w = ~((&top_w) | ~(|top_w));
      ovf_n = ~((&top_n) | ~(|top_n));
      ovf   = mode.wide ? ovf_w : ovf_n;
      neg   = rounded[SW-1];
      if (mode.sat && ovf) begin
         if (mode.wide) res = neg ? LO_WIDE : HI_WIDE;
         else           res = neg ? LO_NARR : HI_NARR;
      end else begin
         res = rounded[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/fmac_sat_unit.sv
module fmac_sat_unit
   import fmac_pkg::*;
#(
   parameter int OP_W     = 16,
   parameter int GUARD_W  = 8,
   parameter bit EVEN_RND = 1'b1,
   localparam int ACC_W   = GUARD_W + 2 * OP_W,
   localparam int PW      = 2 * OP_W + 3,
   localparam int SW      = ACC_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [OP_W-1:0]  opnd_x,
   input  logic [OP_W-1:0]  opnd_y,
   input  logic [ACC_W-1:0] acc_in,
   input  logic             sub_sel,
   input  logic             frac_en,
   input  logic             prod_sat_en,
   input  logic             wide_en,
   input  logic             sat_en,
   input  logic             sext_en,
   input  logic [1:0]       rnd_sel,
   input  logic             ovf_clr,
   output logic [ACC_W-1:0] acc_out,
   output logic             out_valid,
   output logic             carry,
   output logic             ovf_sticky
);
   generate
      if (OP_W < 4) begin : g_bad_op
         $error("fmac_sat_unit: OP_W must be at least 4");
      end
      if (GUARD_W < 1) begin : g_bad_guard
         $error("fmac_sat_unit: GUARD_W must be at least 1");
      end
   endgenerate

   mac_mode_t            mode;
   logic signed [PW-1:0] prod;
   logic signed [SW-1:0] sum, rounded;
   logic [ACC_W-1:0]     res;
   logic                 c_now, ovf_now;

   always_comb begin
      mode.sub  = sub_sel;
      mode.frac = frac_en;
      mode.psat = prod_sat_en;
      mode.wide = wide_en;
      mode.sat  = sat_en;
      mode.sext = sext_en;
      mode.rnd  = rnd_kind_e'(rnd_sel);
   end

   fmac_product #(.OP_W(OP_W)) u_prod (
      .opnd_x (opnd_x),
      .opnd_y (opnd_y),
      .mode   (mode),
      .prod   (prod)
   );

   fmac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
      .acc_in (acc_in),
      .prod   (prod),
      .mode   (mode),
      .sum    (sum),
      .carry  (c_now)
   );

   fmac_round #(.OP_W(OP_W), .SW(SW), .EVEN_RND(EVEN_RND)) u_rnd (
      .sum     (sum),
      .rnd     (mode.rnd),
      .rounded (rounded)
   );

   fmac_saturate #(.OP_W(OP_W), .ACC_W(ACC_W)) u_sat (
      .rounded (rounded),
      .mode    (mode),
      .res     (res),
      .ovf     (ovf_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_out    <= '0;
         out_valid  <= 1'b0;
         carry      <= 1'b0;
         ovf_sticky <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         ovf_sticky <= (in_valid & ovf_now) | (ovf_sticky & ~ovf_clr);
         if (in_valid) begin
            acc_out <= res;
            carry   <= c_now;
         end
      end
   end
endmodule

// File: rtl/fmac_sat_unit_chk.sv
module fmac_sat_unit_chk #(
   parameter int OP_W    = 16,
   parameter int GUARD_W = 8,
   localparam int ACC_W  = GUARD_W + 2 * OP_W,
   localparam int NB     = 2 * OP_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             wide_en,
   input logic             sat_en,
   input logic [1:0]       rnd_sel,
   input logic             ovf_clr,
   input logic [ACC_W-1:0] acc_out,
   input logic             out_valid,
   input logic             carry,
   input logic             ovf_sticky
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(acc_out) && $stable(carry))); // R1
   AST_ROUND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en && (rnd_sel == 2'b01 || rnd_sel == 2'b10)) |=> (acc_out[OP_W-1:0] == '0)); // R6
   AST_NARROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && !wide_en) |=> ((&acc_out[ACC_W-1:NB-1]) || !(|acc_out[ACC_W-1:NB-1]))); // R9
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !ovf_clr) |=> ovf_sticky); // R12
   AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !in_valid) |=> !ovf_sticky); // R12
endmodule

bind fmac_sat_unit fmac_sat_unit_chk #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .wide_en    (wide_en),
   .sat_en     (sat_en),
   .rnd_sel    (rnd_sel),
   .ovf_clr    (ovf_clr),
   .acc_out    (acc_out),
   .out_valid  (out_valid),
   .carry      (carry),
   .ovf_sticky (ovf_sticky)
);

// File: tb/fmac_sat_unit_tb.sv
`timescale 1ns/1ps
module fmac_sat_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] opnd_x = '0, opnd_y = '0;
   logic [39:0] acc_in = '0;
   logic        sub_sel = 0, frac_en = 0, prod_sat_en = 0, wide_en = 0;
   logic        sat_en = 0, sext_en = 0, ovf_clr = 0;
   logic [1:0]  rnd_sel = '0;
   logic [39:0] acc_out;
   logic        out_valid, carry, ovf_sticky;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fmac_sat_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_x(opnd_x), .opnd_y(opnd_y),
      .acc_in(acc_in), .sub_sel(sub_sel), .frac_en(frac_en), .prod_sat_en(prod_sat_en),
      .wide_en(wide_en), .sat_en(sat_en), .sext_en(sext_en), .rnd_sel(rnd_sel),
      .ovf_clr(ovf_clr), .acc_out(acc_out), .out_valid(out_valid), .carry(carry),
      .ovf_sticky(ovf_sticky)
   );

   localparam longint M40 = 64'hFF_FFFF_FFFF;
   localparam longint M32 = 64'hFFFF_FFFF;

   // mode bits: [0] sub, [1] frac, [2] prod clamp, [3] wide, [4] sat, [5] sext, [7:6] round
   function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                 input logic [39:0] acc, input logic [7:0] m,
                                 output logic [39:0] r, output logic c, output logic o);
      longint av, bv, p, ac, s, pm, opd, accu, low, base, rv, sb;
      logic up;
      av = m[5] ? longint'($signed(a)) : longint'(a);
      bv = m[5] ? longint'($signed(b)) : longint'(b);
      p  = av * bv;
      if (m[1]) p = p * 2;
      if (m[2] && p == 64'sd2147483648) p = 64'sd2147483647;
      ac = longint'($signed(acc));
      s  = m[0] ? ac - p : ac + p;
      pm   = p & M40;
      opd  = m[0] ? ((~pm) & M40) : pm;
      accu = longint'(acc);
      sb   = m[0] ? 64'sd1 : 64'sd0;
      if (m[3]) c = ((accu + opd + sb) >>> 40) & 1;
      else      c = (((accu & M32) + (opd & M32) + sb) >>> 32) & 1;
      low  = s & 64'hFFFF;
      base = s - low;
      case (m[7:6])
         2'b01:   begin up = (low >= 32768); rv = base + (up ? 65536 : 0); end
         2'b10:   begin up = (low > 32768) || (low == 32768 && ((s >>> 16) & 1) == 1);
                        rv = base + (up ? 65536 : 0); end
         default: rv = s;
      endcase
      if (m[3]) o = (rv > 64'sd549755813887) || (rv < -64'sd549755813888);
      else      o = (rv > 64'sd2147483647)   || (rv < -64'sd2147483648);
      if (m[4] && o) begin
         if (m[3]) r = (rv < 0) ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF;
         else      r = (rv < 0) ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
      end else begin
         r = rv[39:0];
      end
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [39:0] acc,
                        input logic [7:0] m, input logic v, input logic clr);
      opnd_x = a; opnd_y = b; acc_in = acc;
      sub_sel = m[0]; frac_en = m[1]; prod_sat_en = m[2]; wide_en = m[3];
      sat_en = m[4]; sext_en = m[5]; rnd_sel = m[7:6];
      in_valid = v; ovf_clr = clr;
   endtask

   logic [15:0] ops [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
   logic [39:0] accs [7] = '{40'h00_0000_0000, 40'h00_7FFF_FFFF, 40'hFF_8000_0000,
                             40'h7F_FFFF_0000, 40'h80_0000_8000, 40'h00_0001_8000,
                             40'h00_0000_8000};

   initial begin
      logic [39:0] er, hold_r;
      logic ec, eo, hold_c;
      // R13: reset state
      repeat (3) @(negedge clk);
      check(acc_out == 40'h0 && !out_valid && !carry && !ovf_sticky, "R13 reset state",
            longint'(acc_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: one-cycle latency, R3/R2 on a known product
      drive(16'h4000, 16'h4000, 40'h0, 8'b0010_0010, 1'b1, 1'b1);
      @(negedge clk);
      check(out_valid == 1'b1, "R1 valid after accept", longint'(out_valid), 1);
      check(acc_out == 40'h00_2000_0000, "R3 Q15 half*half", longint'(acc_out), 64'h2000_0000);
      hold_r = acc_out; hold_c = carry;
      // R1: idle cycle with changed inputs is ignored
      drive(16'h7FFF, 16'h7FFF, 40'h12_3456_789A, 8'b0001_1001, 1'b0, 1'b0);
      @(negedge clk);
      check(!out_valid && acc_out == hold_r && carry == hold_c, "R1 hold while idle",
            longint'(acc_out), longint'(hold_r));

      // R4: clamp of most-negative squared, then R9 narrow bound
      drive(16'h8000, 16'h8000, 40'h0, 8'b0010_0110, 1'b1, 1'b1);
      @(negedge clk);
      check(acc_out == 40'h00_7FFF_FFFF && !ovf_sticky, "R4 product clamp", longint'(acc_out), 64'h7FFF_FFFF);

      // R12: sticky overflow set, kept, then cleared
      drive(16'h0001, 16'h0001, 40'h00_7FFF_FFFF, 8'b0010_0000, 1'b1, 1'b0);
      @(negedge clk);
      check(ovf_sticky == 1'b1, "R12 set on overflow", longint'(ovf_sticky), 1);
      drive(16'h0000, 16'h0000, 40'h0, 8'b0010_0000, 1'b1, 1'b0);
      @(negedge clk);
      check(ovf_sticky == 1'b1, "R12 kept without clear", longint'(ovf_sticky), 1);
      drive(16'h0000, 16'h0000, 40'h0, 8'b0010_0000, 1'b0, 1'b1);
      @(negedge clk);
      check(ovf_sticky == 1'b0, "R12 cleared by pulse", longint'(ovf_sticky), 0);
      drive(16'h0001, 16'h0001, 40'h00_7FFF_FFFF, 8'b0010_0000, 1'b1, 1'b1);
      @(negedge clk);
      check(ovf_sticky == 1'b1, "R12 overflow wins over clear", longint'(ovf_sticky), 1);

      // Sweep: operands x operands x accumulators x all 256 mode words
      for (int ia = 0; ia < 6; ia++) begin
         for (int ib = 0; ib < 6; ib++) begin
            for (int ic = 0; ic < 7; ic++) begin
               for (int m = 0; m < 256; m++) begin
                  drive(ops[ia], ops[ib], accs[ic], 8'(m), 1'b1, 1'b1);
                  model(ops[ia], ops[ib], accs[ic], 8'(m), er, ec, eo);
                  @(negedge clk);
                  check(acc_out == er, "R2/R3/R4/R5/R6/R7/R8/R9/R10 result",
                        longint'(acc_out), longint'(er));
                  check(carry == ec, "R11 carry", longint'(carry), longint'(ec));
                  check(ovf_sticky == eo, "R8/R12 overflow flag", longint'(ovf_sticky), longint'(eo));
               end
            end
         end
      end

      // R7: explicit ties
      drive(16'h0000, 16'h0000, 40'h00_0000_8000, 8'b1000_0000, 1'b1, 1'b1);
      @(negedge clk);
      check(acc_out == 40'h0, "R7 tie to even down", longint'(acc_out), 0);
      drive(16'h0000, 16'h0000, 40'h00_0001_8000, 8'b1000_0000, 1'b1, 1'b1);
      @(negedge clk);
      check(acc_out == 40'h00_0002_0000, "R7 tie to even up", longint'(acc_out), 64'h2_0000);
      // R10: wide positive bound
      drive(16'h7FFF, 16'h7FFF, 40'h7F_FFFF_0000, 8'b0011_1000, 1'b1, 1'b1);
      @(negedge clk);
      check(acc_out == 40'h7F_FFFF_FFFF, "R10 wide positive clamp", longint'(acc_out), 64'h7F_FFFF_FFFF);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule